// File: doc/BRIEF.md
# Mixed-Width Interval Timer Bank

This block holds four counters behind a small 32-bit register bus. Three of them are down-counters: two 16 bits wide and one 32 bits wide. Each counts one step per tick strobe and raises a level interrupt when it passes below zero. In periodic mode an underflow refills the counter from its load register. In free-running mode an underflow wraps the counter to all ones. The fourth counter is a 40-bit up-counter with no interrupt. Software reads it as time since it was enabled.

Time does not come from the clock directly. Two single-cycle enable strobes arrive from outside the block. `tick_slow` is the general timebase, near 508 kHz in the intended system. `tick_fast` is the quicker timebase, near 983 kHz. Each down-counter picks one of the two through a control bit. The 40-bit counter always uses the fast strobe. The 40-bit value is wider than the bus, so reading its low word also snapshots its upper eight bits. The next read of the upper register then returns the bits that belong with that low word.

Top module: `tmr_bank`

## Requirements
- R1: After reset every counter, load register, control register, interrupt and the 40-bit enable are zero, so every register reads 0 and `irq` is 0.
- R2: The timer register blocks start at 0x00, 0x20 and 0x80, with word offsets load +0x0, live value +0x4, control +0x8 and clear +0xC. Writing a load register stores the value and sets the live count to it in the same cycle. The load register and the value register both read back zero-extended to 32 bits.
- R3: An enabled down-counter (control bit 7 = 1) decrements by one on each strobe of its selected timebase. A disabled one holds its count.
- R4: Control bit 3 = 1 selects `tick_fast` and bit 3 = 0 selects `tick_slow`. Strobes on the other timebase have no effect on the count.
- R5: With control bit 6 = 1 (periodic), a load value N gives one underflow every N+1 selected strobes, and each underflow refills the count with N.
- R6: With control bit 6 = 0, an underflow wraps the count to all ones: 0xFFFF for a 16-bit timer and 0xFFFFFFFF for the 32-bit one.
- R7: An underflow sets that timer's bit in `irq` (bit 0 = first 16-bit timer, bit 1 = second, bit 2 = 32-bit timer). The bit stays set until any value is written to that timer's clear register. A clear write to one timer leaves the other interrupt bits unchanged.
- R8: The control register keeps only bits 7, 6 and 3. All other bits read as zero.
- R9: Writing the upper register at 0x64 sets the 40-bit counter's enable from data bit 8. When enabled, the counter increments once per `tick_fast` strobe. `tick_slow` never moves it.
- R10: A read of 0x60 returns count bits 31:0 and snapshots bits 39:32. A read of 0x64 returns that snapshot in bits 7:0 and the enable flag in bit 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_slow | input | 1 | Single-cycle strobe of the general timebase |
| tick_fast | input | 1 | Single-cycle strobe of the faster timebase |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used for the 40-bit snapshot) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 3 | Level interrupts of the three down-counters |

## Verification
The bench builds the block with its default widths: 16, 16, 32 and 40 bits. This keeps the truncation of 32-bit bus writes into the 16-bit timers visible, together with the all-ones wrap value of each width. Short load values bring underflow, reload and wrap within a few strobes. The 40-bit counter can only run a few thousand strobes in a run, so its bits 39:32 stay zero. The bench therefore checks the snapshot path for its enable flag and field position. The carry into the upper byte is left to the checker's step property on the counter.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 32;
    localparam int NUM_DOWN     = 3;

    // control register bit positions (software decodes these)
    localparam int CTL_EN_BIT   = 7;
    localparam int CTL_PER_BIT  = 6;
    localparam int CTL_SEL_BIT  = 3;

    // register word index inside a down-counter block
    localparam logic [1:0] SUB_LOAD  = 2'd0;
    localparam logic [1:0] SUB_VALUE = 2'd1;
    localparam logic [1:0] SUB_CTRL  = 2'd2;
    localparam logic [1:0] SUB_CLEAR = 2'd3;

    localparam logic [ADDR_W-1:0] FREE_LO_ADDR = 8'h60;
    localparam logic [ADDR_W-1:0] FREE_HI_ADDR = 8'h64;
    localparam int                FREE_EN_BIT  = 8;

    typedef struct packed {
        logic en;
        logic periodic;
        logic sel_fast;
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] down_base(input int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'h20;
            default: return 8'h80;
        endcase
    endfunction

endpackage

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_slow,
    input  logic         tick_fast,
    input  logic         ld_wr,
    input  logic [W-1:0] ld_data,
    input  logic         ctl_wr,
    input  ctrl_t        ctl_data,
    input  logic         clr_wr,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] load_o,
    output ctrl_t        ctl_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] load;
        ctrl_t        ctl;
        logic         irq;
    } state_t;

    state_t state_d, state_q;
    logic   step;

    always_comb begin
        state_d = state_q;
        step    = state_q.ctl.sel_fast ? tick_fast : tick_slow;

        if (ctl_wr) begin
            state_d.ctl = ctl_data;
        end
        if (clr_wr) begin
            state_d.irq = 1'b0;
        end

        if (ld_wr) begin
            state_d.load = ld_data;
            state_d.cnt  = ld_data;
        end else if (state_q.ctl.en && step) begin
            if (state_q.cnt == '0) begin
                state_d.cnt = state_q.ctl.periodic ? state_q.load : '1;
                state_d.irq = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o  = state_q.cnt;
    assign load_o = state_q.load;
    assign ctl_o  = state_q.ctl;
    assign irq_o  = state_q.irq;

endmodule

// File: rtl/tmr_free_cnt.sv
module tmr_free_cnt #(
    parameter int W = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en_wr,
    input  logic          en_val,
    input  logic          lo_rd,
    output logic [W-1:0]  cnt_o,
    output logic          en_o,
    output logic [W-33:0] hi_snap_o
);

    localparam int HI_W = W - 32;

    typedef struct packed {
        logic [W-1:0]    cnt;
        logic            en;
        logic [HI_W-1:0] hi_snap;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (en_wr) begin
            state_d.en = en_val;
        end
        if (state_q.en && tick) begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
        if (lo_rd) begin
            state_d.hi_snap = state_q.cnt[W-1:32];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o     = state_q.cnt;
    assign en_o      = state_q.en;
    assign hi_snap_o = state_q.hi_snap;

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int SHORT_W = 16,
    parameter int LONG_W  = 32,
    parameter int FREE_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_slow,
    input  logic              tick_fast,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_DOWN-1:0] irq
);

    localparam int HI_W = FREE_W - 32;

    logic [1:0]        sub;
    logic [NUM_DOWN-1:0] hit;
    logic [DATA_W-1:0] load_ext [NUM_DOWN];
    logic [DATA_W-1:0] cnt_ext  [NUM_DOWN];
    logic [DATA_W-1:0] ctl_ext  [NUM_DOWN];
    ctrl_t             ctl_wdata;

    logic [FREE_W-1:0] free_cnt;
    logic              free_en;
    logic [HI_W-1:0]   free_hi_snap;
    logic              lo_hit, hi_hit;

    assign sub       = bus_addr[3:2];
    assign ctl_wdata = '{en:       bus_wdata[CTL_EN_BIT],
                         periodic: bus_wdata[CTL_PER_BIT],
                         sel_fast: bus_wdata[CTL_SEL_BIT]};

    for (genvar i = 0; i < NUM_DOWN; i++) begin : g_down
        localparam int                W    = (i == NUM_DOWN - 1) ? LONG_W : SHORT_W;
        localparam logic [ADDR_W-1:0] BASE = down_base(i);

        logic [W-1:0] cnt_w, load_w;
        ctrl_t        ctl_w;

        assign hit[i] = (bus_addr[7:4] == BASE[7:4]) && (bus_addr[1:0] == 2'b00);

        tmr_down_cnt #(.W(W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_slow (tick_slow),
            .tick_fast (tick_fast),
            .ld_wr     (bus_wr && hit[i] && (sub == SUB_LOAD)),
            .ld_data   (bus_wdata[W-1:0]),
            .ctl_wr    (bus_wr && hit[i] && (sub == SUB_CTRL)),
            .ctl_data  (ctl_wdata),
            .clr_wr    (bus_wr && hit[i] && (sub == SUB_CLEAR)),
            .cnt_o     (cnt_w),
            .load_o    (load_w),
            .ctl_o     (ctl_w),
            .irq_o     (irq[i])
        );

        assign cnt_ext[i]  = DATA_W'(cnt_w);
        assign load_ext[i] = DATA_W'(load_w);

        always_comb begin
            ctl_ext[i]              = '0;
            ctl_ext[i][CTL_EN_BIT]  = ctl_w.en;
            ctl_ext[i][CTL_PER_BIT] = ctl_w.periodic;
            ctl_ext[i][CTL_SEL_BIT] = ctl_w.sel_fast;
        end
    end

    assign lo_hit = (bus_addr == FREE_LO_ADDR);
    assign hi_hit = (bus_addr == FREE_HI_ADDR);

    tmr_free_cnt #(.W(FREE_W)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_fast),
        .en_wr     (bus_wr && hi_hit),
        .en_val    (bus_wdata[FREE_EN_BIT]),
        .lo_rd     (bus_rd && lo_hit),
        .cnt_o     (free_cnt),
        .en_o      (free_en),
        .hi_snap_o (free_hi_snap)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_DOWN; i++) begin
            if (hit[i]) begin
                case (sub)
                    SUB_LOAD:  bus_rdata = load_ext[i];
                    SUB_VALUE: bus_rdata = cnt_ext[i];
                    SUB_CTRL:  bus_rdata = ctl_ext[i];
                    default:   bus_rdata = '0;
                endcase
            end
        end
        if (lo_hit) begin
            bus_rdata = free_cnt[31:0];
        end
        if (hi_hit) begin
            bus_rdata[HI_W-1:0]  = free_hi_snap;
            bus_rdata[FREE_EN_BIT] = free_en;
        end
    end

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
    import tmr_pkg::*;
#(
    parameter int FREE_W = 40
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_slow,
    input logic                tick_fast,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [NUM_DOWN-1:0] irq,
    input logic [FREE_W-1:0]   free_cnt,
    input logic                free_en
);

    // R1: held reset leaves every interrupt low
    p_irq_reset_r1: assert property (@(posedge clk) !rst_n |=> (irq == '0));

    // R3: with no strobe and no write nothing can change an interrupt
    p_irq_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_slow && !tick_fast && !bus_wr) |=> $stable(irq));

    for (genvar i = 0; i < NUM_DOWN; i++) begin : g_irq
        localparam logic [ADDR_W-1:0] CLR_ADDR = down_base(i) + 8'h0C;

        // R7: an interrupt drops only after a write to its own clear register
        p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[i]) |-> $past(bus_wr && (bus_addr == CLR_ADDR)));

        // R7: an interrupt rises only after a timebase strobe
        p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> $past(tick_slow || tick_fast));
    end

    // R9: the 40-bit counter never moves without a fast strobe
    p_free_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_fast |=> $stable(free_cnt));

    // R9: enabled and strobed, it advances by exactly one, carry included
    p_free_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_fast && free_en) |=> (free_cnt == $past(free_cnt) + 1'b1));

endmodule

bind tmr_bank tmr_bank_chk #(.FREE_W(FREE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_slow (tick_slow),
    .tick_fast (tick_fast),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .irq       (irq),
    .free_cnt  (free_cnt),
    .free_en   (free_en)
);

// File: tb/tb_tmr_bank.sv
`timescale 1ns/1ps
module tb_tmr_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_slow = 1'b0;
    logic        tick_fast = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tmr_bank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_slow (tick_slow),
        .tick_fast (tick_fast),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic pulse(input bit fast, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
            @(negedge clk);
            tick_fast = 1'b0;
            tick_slow = 1'b0;
        end
    endtask

    task automatic quiesce();
        wr(8'h08, 0); wr(8'h28, 0); wr(8'h88, 0);
        wr(8'h0C, 0); wr(8'h2C, 0); wr(8'h8C, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {29'd0, irq}, 32'd0);
        foreach (dut.hit[i]) begin end
        for (int i = 0; i < 3; i++) begin
            logic [7:0] b;
            b = (i == 0) ? 8'h00 : (i == 1) ? 8'h20 : 8'h80;
            rd(b,        v); check("R1 load", v, 0);
            rd(b + 8'h4, v); check("R1 value", v, 0);
            rd(b + 8'h8, v); check("R1 ctrl", v, 0);
        end
        rd(8'h60, v); check("R1 free low", v, 0);
        rd(8'h64, v); check("R1 free high", v, 0);
    endtask

    task automatic t_load();
        logic [31:0] v;
        wr(8'h00, 32'hABCD_1234);
        rd(8'h04, v); check("R2 t1 value zero-extended", v, 32'h0000_1234);
        rd(8'h00, v); check("R2 t1 load zero-extended", v, 32'h0000_1234);
        wr(8'h20, 32'h0001_0042);
        rd(8'h24, v); check("R2 t2 value", v, 32'h0000_0042);
        wr(8'h80, 32'hDEAD_BEEF);
        rd(8'h84, v); check("R2 t3 full width", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, v); check("R8 ctrl keeps bits 7,6,3", v, 32'h0000_00C8);
        quiesce();
    endtask

    task automatic t_hold_and_count();
        logic [31:0] v;
        wr(8'h00, 10);
        pulse(0, 3);
        rd(8'h04, v); check("R3 disabled holds", v, 10);
        wr(8'h08, 32'hC0);
        pulse(0, 3);
        rd(8'h04, v); check("R3 counts slow strobes", v, 7);
        pulse(1, 2);
        rd(8'h04, v); check("R4 fast ignored when select=0", v, 7);
        quiesce();
    endtask

    task automatic t_select();
        logic [31:0] v;
        wr(8'h20, 20);
        wr(8'h28, 32'hC8);
        pulse(0, 2);
        rd(8'h24, v); check("R4 slow ignored when select=1", v, 20);
        pulse(1, 5);
        rd(8'h24, v); check("R4 counts fast strobes", v, 15);
        quiesce();
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(8'h00, 3);
        wr(8'h08, 32'hC0);
        pulse(0, 3);
        rd(8'h04, v); check("R5 reaches zero after N", v, 0);
        check("R7 no irq before underflow", {29'd0, irq}, 0);
        pulse(0, 1);
        rd(8'h04, v); check("R5 reload after N+1", v, 3);
        check("R7 only timer 1 irq", {29'd0, irq}, 32'd1);
        wr(8'h2C, 32'h5A5A);
        check("R7 other clear leaves irq", {29'd0, irq}, 32'd1);
        wr(8'h0C, 32'h1234);
        check("R7 clear by any value", {29'd0, irq}, 0);
        pulse(0, 3);
        check("R5 no irq at N ticks", {29'd0, irq}, 0);
        pulse(0, 1);
        check("R5 second period irq", {29'd0, irq}, 32'd1);
        quiesce();
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(8'h80, 1);
        wr(8'h88, 32'h80);
        pulse(0, 2);
        rd(8'h84, v); check("R6 t3 wraps to all ones", v, 32'hFFFF_FFFF);
        check("R7 t3 irq", {29'd0, irq}, 32'd4);
        wr(8'h20, 0);
        wr(8'h28, 32'h88);
        pulse(1, 1);
        rd(8'h24, v); check("R6 t2 wraps to 0xFFFF", v, 32'h0000_FFFF);
        check("R7 t2 and t3 irq", {29'd0, irq}, 32'd6);
        quiesce();
    endtask

    task automatic t_free();
        logic [31:0] v;
        pulse(1, 3);
        rd(8'h60, v); check("R9 disabled counter stays 0", v, 0);
        wr(8'h64, 32'h0000_0100);
        pulse(1, 5);
        rd(8'h60, v); check("R9 counts fast strobes", v, 5);
        rd(8'h64, v); check("R10 high read: enable bit 8, snapshot 0", v, 32'h0000_0100);
        pulse(0, 4);
        rd(8'h60, v); check("R9 slow strobes ignored", v, 5);
        wr(8'h64, 0);
        pulse(1, 2);
        rd(8'h60, v); check("R9 disable stops count", v, 5);
        rd(8'h64, v); check("R10 high read after disable", v, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_ctrl();
        t_hold_and_count();
        t_select();
        t_periodic();
        t_wrap();
        t_free();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule